// File: doc/BRIEF.md
# Host Read Port with Address-Aliased Receive FIFO Access

This block sits between an asynchronous 16-bit host read bus and a 32-bit receive data FIFO. When the host raises the FIFO-select input during a read, the read goes to the receive FIFO no matter what the upper address bits hold. A host that can only step its address on every access can still stream received data out. The lowest word-select address bit picks the low or the high half of the FIFO head word. A separate select input can swap the two bytes of the returned half-word.

Chip-select and read strobe are active low and come from the host clock domain. Each passes through a synchroniser. A cycle opens when both strobes are seen low and closes when either one goes high again. Reading the high half consumes the FIFO entry with a one-clock pop pulse when the cycle closes. Reading an empty FIFO returns zero, does not pop, and sets a sticky underflow flag. Ordinary register decoding and the write path belong to other blocks. Reads made with the FIFO-select input low leave this port idle.

Top module: `hpio_rx_port`

## Requirements
- R1: While rst_n is low, host_rdata_oe, rxf_pop and uflow are 0 and host_rdata is all zeros.
- R2: A cycle opens only when host_cs_n and host_rd_n are both low. With only one of them low, host_rdata_oe stays 0. host_rdata_oe rises on the third rising clock edge after both are low.
- R3: A cycle closes when either strobe goes high, whichever strobe asserted first. host_rdata_oe falls on the third rising clock edge after that, and host_rdata is all zeros whenever host_rdata_oe is 0.
- R4: When host_fifo_sel is low for a cycle, host_rdata_oe stays 0, host_rdata stays zero, no pop occurs and uflow is unchanged, even with an empty FIFO.
- R5: In FIFO mode, host_addr[0] (host address weight 2) steers the data: 0 returns rxf_data[15:0], 1 returns rxf_data[31:16]. host_addr[8:1] have no effect.
- R6: With host_swap_sel high, the two bytes of the returned half-word are exchanged, so half {b1,b0} is returned as {b0,b1}.
- R7: rxf_pop is high for exactly one clock, starting on the edge where host_rdata_oe falls. It fires only for a FIFO-mode cycle with host_addr[0]=1 that started on a non-empty FIFO. A low-half read never pops.
- R8: A FIFO-mode cycle that starts with rxf_empty high drives all zeros with host_rdata_oe high, does not pop, and sets uflow on the edge where host_rdata_oe rises.
- R9: uflow stays set until uflow_clr is high at a rising edge. A new underflow on that same edge wins over the clear.
- R10: host_rdata is loaded once when the cycle opens and stays constant while host_rdata_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_fifo_sel | input | 1 | High: the read goes to the receive FIFO |
| host_swap_sel | input | 1 | High: swap the bytes of the returned half-word |
| host_addr | input | 9 | Host word address, bit 0 is the half-word select |
| host_rdata | output | 16 | Read data, zero when not driven |
| host_rdata_oe | output | 1 | Output enable for the external data pad |
| rxf_data | input | 32 | Head entry of the receive FIFO |
| rxf_empty | input | 1 | Receive FIFO holds no entry |
| rxf_pop | output | 1 | One-clock pop of the FIFO head |
| uflow_clr | input | 1 | Synchronous clear of the underflow flag |
| uflow | output | 1 | Sticky flag for a read of an empty FIFO |

## Verification
Strobe edges cross two synchroniser flops and one edge-detect flop, so host_rdata_oe, host_rdata and uflow change on the third rising edge after the strobes reach the state that opens a cycle. host_rdata_oe and rxf_pop change on the third rising edge after the strobe that closes it. The bench drives inputs on falling edges and samples on falling edges. It checks that an output has not yet changed at the second falling edge and has changed at the third. It also checks that rxf_pop has dropped again one falling edge later. Expected half-words, swaps, pop counts and the underflow flag come from a bench model of the FIFO, updated as each pop is observed.

// File: rtl/hpio_pkg.sv
package hpio_pkg;

   // Attributes of a host read cycle, captured when the cycle opens
   typedef struct packed {
      logic fifo_mode;   // read goes to the receive FIFO
      logic last_half;   // selected half is the top one, so the entry is consumed
      logic was_empty;   // FIFO had no entry when the cycle opened
   } hpio_cyc_t;

endpackage

// File: rtl/hpio_sync.sv
module hpio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hpio_cycle_det.sv
module hpio_cycle_det (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic rd_n_s,
   output logic open_p,
   output logic close_p
);

   logic active, active_q;

   // a cycle exists only while both synchronised strobes are low
   assign active = ~cs_n_s & ~rd_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active;
   end

   assign open_p  =  active & ~active_q;
   assign close_p = ~active &  active_q;

endmodule

// File: rtl/hpio_steer.sv
module hpio_steer #(
   parameter int FIFO_W = 32,
   parameter int BUS_W  = 16,
   parameter int SEL_W  = 1
) (
   input  logic [FIFO_W-1:0] word,
   input  logic [SEL_W-1:0]  sel,
   input  logic              swap,
   output logic [BUS_W-1:0]  half
);

   localparam int HALVES = FIFO_W / BUS_W;
   localparam int BYTES  = BUS_W / 8;

   logic [BUS_W-1:0] parts [HALVES];
   logic [BUS_W-1:0] picked, swapped;

   generate
      for (genvar g = 0; g < HALVES; g++) begin : g_part
         assign parts[g] = word[g*BUS_W +: BUS_W];
      end
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         assign swapped[b*8 +: 8] = picked[(BYTES-1-b)*8 +: 8];
      end
   endgenerate

   assign picked = parts[sel];
   assign half   = swap ? swapped : picked;

endmodule

// File: rtl/hpio_rx_port.sv
module hpio_rx_port
   import hpio_pkg::*;
#(
   parameter int FIFO_W      = 32,
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_rd_n,
   input  logic              host_fifo_sel,
   input  logic              host_swap_sel,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [BUS_W-1:0]  host_rdata,
   output logic              host_rdata_oe,
   input  logic [FIFO_W-1:0] rxf_data,
   input  logic              rxf_empty,
   output logic              rxf_pop,
   input  logic              uflow_clr,
   output logic              uflow
);

   localparam int HALVES = FIFO_W / BUS_W;
   localparam int SEL_W  = (HALVES > 1) ? $clog2(HALVES) : 1;
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(HALVES - 1);

   generate
      if (BUS_W % 8 != 0) begin : g_bad_bus
         $error("hpio_rx_port: BUS_W must be a whole number of bytes");
      end
      if (FIFO_W % BUS_W != 0 || HALVES < 2) begin : g_bad_ratio
         $error("hpio_rx_port: FIFO_W must be at least two BUS_W halves");
      end
      if ((HALVES & (HALVES - 1)) != 0) begin : g_bad_pow2
         $error("hpio_rx_port: FIFO_W / BUS_W must be a power of two");
      end
      if (SEL_W >= ADDR_W) begin : g_bad_addr
         $error("hpio_rx_port: ADDR_W too narrow for the half select");
      end
   endgenerate

   // ---- strobe synchronisation and cycle detection
   logic cs_n_s, rd_n_s, open_p, close_p;

   hpio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(host_cs_n), .q(cs_n_s));
   hpio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
      .clk(clk), .rst_n(rst_n), .d(host_rd_n), .q(rd_n_s));

   hpio_cycle_det u_det (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .rd_n_s(rd_n_s),
      .open_p(open_p), .close_p(close_p));

   // ---- data steering: only the half-select bits matter
   logic [SEL_W-1:0] half_sel;
   logic [BUS_W-1:0] half;
   logic             unused_upper_addr;

   assign half_sel          = host_addr[SEL_W-1:0];
   assign unused_upper_addr = ^host_addr[ADDR_W-1:SEL_W];

   hpio_steer #(.FIFO_W(FIFO_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_steer (
      .word(rxf_data), .sel(half_sel), .swap(host_swap_sel), .half(half));

   // ---- cycle state, read data and pop
   hpio_cyc_t cyc_q;
   logic      serve;

   assign serve = host_fifo_sel & ~rxf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q         <= '0;
         host_rdata    <= '0;
         host_rdata_oe <= 1'b0;
         rxf_pop       <= 1'b0;
      end else begin
         rxf_pop <= 1'b0;
         if (open_p) begin
            cyc_q.fifo_mode <= host_fifo_sel;
            cyc_q.last_half <= (half_sel == LAST_SEL);
            cyc_q.was_empty <= rxf_empty;
            host_rdata_oe   <= host_fifo_sel;
            host_rdata      <= serve ? half : '0;
         end else if (close_p) begin
            rxf_pop       <= cyc_q.fifo_mode & cyc_q.last_half & ~cyc_q.was_empty;
            host_rdata_oe <= 1'b0;
            host_rdata    <= '0;
            cyc_q         <= '0;
         end
      end
   end

   // ---- sticky underflow, set wins over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  uflow <= 1'b0;
      else if (open_p && host_fifo_sel && rxf_empty) uflow <= 1'b1;
      else if (uflow_clr)                          uflow <= 1'b0;
   end

endmodule

// File: rtl/hpio_rx_port_chk.sv
module hpio_rx_port_chk #(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [BUS_W-1:0] host_rdata,
   input logic             host_rdata_oe,
   input logic             rxf_empty,
   input logic             rxf_pop,
   input logic             uflow_clr,
   input logic             uflow
);

   AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |=> !rxf_pop); // R7
   AST_POP_AT_OE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> (!host_rdata_oe && $past(host_rdata_oe))); // R7
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_pop |-> !rxf_empty); // R8
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdata_oe |-> (host_rdata == '0)); // R3
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata_oe && $past(host_rdata_oe)) |-> $stable(host_rdata)); // R10
   AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow && !uflow_clr) |=> uflow); // R9

endmodule

bind hpio_rx_port hpio_rx_port_chk #(.BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata),
   .host_rdata_oe(host_rdata_oe), .rxf_empty(rxf_empty), .rxf_pop(rxf_pop),
   .uflow_clr(uflow_clr), .uflow(uflow));

// File: tb/hpio_rx_port_tb_top.sv
module hpio_rx_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs_n = 1'b1, host_rd_n = 1'b1;
   logic        host_fifo_sel = 1'b0, host_swap_sel = 1'b0;
   logic [8:0]  host_addr = '0;
   logic [15:0] host_rdata;
   logic        host_rdata_oe;
   logic [31:0] rxf_data;
   logic        rxf_empty;
   logic        rxf_pop;
   logic        uflow_clr = 1'b0;
   logic        uflow;

   always #4 clk = ~clk;   // 125 MHz

   // bench FIFO model
   logic [31:0] mem [0:63];
   logic [6:0]  rd_p = '0, wr_p = '0;
   int          pops = 0;
   assign rxf_data  = mem[rd_p[5:0]];
   assign rxf_empty = (rd_p == wr_p);
   always @(posedge clk) if (rxf_pop) begin rd_p <= rd_p + 7'd1; pops <= pops + 1; end

   hpio_rx_port dut_i (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
      .host_fifo_sel(host_fifo_sel), .host_swap_sel(host_swap_sel),
      .host_addr(host_addr), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
      .rxf_data(rxf_data), .rxf_empty(rxf_empty), .rxf_pop(rxf_pop),
      .uflow_clr(uflow_clr), .uflow(uflow));

   int   errs = 0, checks = 0;
   logic uf_exp = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_half(input logic [31:0] w, input logic a1, input logic sw);
      logic [15:0] h;
      h = a1 ? w[31:16] : w[15:0];
      return sw ? {h[7:0], h[15:8]} : h;
   endfunction

   task automatic push(input logic [31:0] v);
      mem[wr_p[5:0]] = v;
      wr_p = wr_p + 7'd1;
   endtask

   task automatic do_read(input logic sel, input logic sw, input logic [8:0] a,
                          input logic cs_first, input logic cs_drops_first);
      logic        emp, exp_pop;
      logic [15:0] exp;
      int          p0;
      emp     = (rd_p == wr_p);
      exp     = (sel && !emp) ? ref_half(mem[rd_p[5:0]], a[0], sw) : 16'h0;
      exp_pop = sel && a[0] && !emp;
      p0      = pops;
      host_fifo_sel = sel; host_swap_sel = sw; host_addr = a;
      if (cs_first) host_cs_n = 1'b0; else host_rd_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 single strobe opens nothing", host_rdata_oe, 0);
      if (cs_first) host_rd_n = 1'b0; else host_cs_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 oe not before third edge", host_rdata_oe, 0);
      @(negedge clk);
      chk("R2 R4 oe after open", host_rdata_oe, sel);
      chk("R5 R6 R8 R4 read data", host_rdata, exp);
      if (sel && emp) uf_exp = 1'b1;
      chk("R8 R4 underflow flag", uflow, uf_exp);
      repeat (2) @(negedge clk);
      chk("R10 data held", host_rdata, exp);
      if (cs_drops_first) host_cs_n = 1'b1; else host_rd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3 oe until third edge", host_rdata_oe, sel);
      chk("R7 no early pop", rxf_pop, 0);
      @(negedge clk);
      chk("R3 oe off", host_rdata_oe, 0);
      chk("R3 idle data zero", host_rdata, 0);
      chk("R7 pop on close", rxf_pop, exp_pop);
      @(negedge clk);
      chk("R7 pop one clock", rxf_pop, 0);
      host_cs_n = 1'b1; host_rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 R4 pop count", pops - p0, exp_pop);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", host_rdata_oe, 0);
      chk("R1 data in reset", host_rdata, 0);
      chk("R1 pop in reset", rxf_pop, 0);
      chk("R1 uflow in reset", uflow, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed corner cases
      push(32'hA1B2_C3D4);
      push(32'h1122_3344);
      do_read(1, 0, 9'h000, 1, 1);  // R5 low half, no pop
      do_read(1, 0, 9'h001, 0, 0);  // R5 high half, pop
      do_read(1, 1, 9'h1FE, 1, 0);  // R5 upper bits ignored, R6 swap
      do_read(0, 0, 9'h001, 0, 1);  // R4 no service
      do_read(1, 1, 9'h155, 1, 1);  // R6 R7 high half, pop
      do_read(1, 0, 9'h001, 0, 0);  // R8 empty read
      do_read(0, 0, 9'h000, 1, 0);  // R4 empty, no underflow change
      uflow_clr = 1'b1;
      @(negedge clk);
      uflow_clr = 1'b0;
      uf_exp = 1'b0;
      chk("R9 uflow cleared", uflow, 0);
      do_read(1, 0, 9'h000, 1, 1);  // R8 sets again
      @(negedge clk);
      chk("R9 uflow sticky", uflow, 1);
      uflow_clr = 1'b1; @(negedge clk); uflow_clr = 1'b0; uf_exp = 1'b0;

      // constrained random
      void'($urandom(32'd2024));
      for (int i = 0; i < 80; i++) begin
         if ((7'(wr_p - rd_p) < 7'd48) && ($urandom % 3 != 0)) begin
            for (int k = 0; k < 1 + int'($urandom % 3); k++) push($urandom);
         end
         do_read(($urandom % 5) != 0, $urandom % 2, 9'($urandom),
                 $urandom % 2, $urandom % 2);
         if ($urandom % 8 == 0) begin
            uflow_clr = 1'b1; @(negedge clk); uflow_clr = 1'b0; uf_exp = 1'b0;
            chk("R9 random clear", uflow, 0);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule